// File: doc/BRIEF.md
# Accumulator Operate Microinstruction Unit

This unit carries out the combinable operate group of a small accumulator machine. It holds a 16-bit accumulator and a one-bit link. It accepts one instruction word per cycle, together with a 16-bit switch-register value. Several micro-actions can be packed into a single word. The unit applies them in a fixed sequence within one clock cycle:

1. Clear actions.
2. Complement actions.
3. Increment, then OR-in of the switches.

The register updates at the end of that cycle.

A run flag gates execution. While the flag is low, instruction words have no effect. A one-cycle pulse on the start input raises the flag. An operate word whose most significant bit is clear is a halt: its micro-actions still take effect, and the flag drops at the end of that same instruction. Words that fall outside the operate group (any of bits 14 down to 6 set) are left to other units and do not touch the state here.

Top module: `opr_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the accumulator is 0, the link is 0 and the run flag is 0.
- R2: The run flag rises only in the cycle after a start pulse. While the flag is low, including the cycle in which start is high, instruction words leave the accumulator and link unchanged.
- R3: In the first phase, bit 0 clears the accumulator and bit 3 clears the link.
- R4: In the second phase, which acts on the result of the first, bit 1 inverts the accumulator and bit 4 inverts the link. Word 0x8003 therefore yields 0xFFFF.
- R5: In the third phase, bit 2 adds one to the accumulator, and a carry out of bit 15 inverts the link. Word 0x8006 yields the two's complement of the accumulator.
- R6: Bit 5 ORs the switch value into the accumulator and inverts the link. Combined with bit 0, it loads the switches.
- R7: When bits 2 and 5 are both set, the increment (with its possible link inversion) happens first, and the OR with its link inversion happens second.
- R8: An operate word with bit 15 clear applies its micro-actions and clears the run flag at the end of that instruction. Later words are ignored until the next start pulse. A start pulse in the same cycle as a halt keeps the flag set.
- R9: A word with any of bits 14 to 6 set does not change the accumulator, the link or the run flag.
- R10: An accepted word's result is visible on the outputs after the next rising clock edge; each instruction takes one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| start | input | 1 | One-cycle pulse that sets the run flag |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word |
| switches | input | 16 | Switch-register value used by the OR action |
| acc | output | 16 | Accumulator |
| link | output | 1 | Link bit |
| running | output | 1 | Run flag |

## Verification
The accumulator, the link and the run flag are all registered once after the word is accepted. Every result is therefore due one rising edge after the cycle in which the word was presented.

The driver presents each word at a falling edge and queues the expected state. The monitor compares two nanoseconds after the following rising edge, so each comparison sees exactly one clocked update.

Ignored-word cases (halted, start cycle, non-group word) also queue an expectation equal to the unchanged state, so their lack of effect is observed at the ports in that same slot.

// File: rtl/opr_pkg.sv
package opr_pkg;
  typedef struct packed {
    logic clr_ac;
    logic clr_l;
    logic cmp_ac;
    logic cmp_l;
    logic inc_ac;
    logic or_sw;
    logic halt;
    logic legal;
  } opr_ctl_t;
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] instr,
  output opr_ctl_t     ctl
);
  localparam int GRP_LO = 6;
  localparam int GRP_HI = W - 2;

  always_comb begin
    ctl.clr_ac = instr[0];
    ctl.cmp_ac = instr[1];
    ctl.inc_ac = instr[2];
    ctl.clr_l  = instr[3];
    ctl.cmp_l  = instr[4];
    ctl.or_sw  = instr[5];
    ctl.halt   = ~instr[W-1];
    ctl.legal  = ~|instr[GRP_HI:GRP_LO];
  end
endmodule

// File: rtl/opr_alu.sv
module opr_alu
  import opr_pkg::*;
#(
  parameter int W = 16
) (
  input  opr_ctl_t     ctl,
  input  logic [W-1:0] ac,
  input  logic         l,
  input  logic [W-1:0] sw,
  output logic [W-1:0] ac_n,
  output logic         l_n
);
  logic [W-1:0] a1, a2, a3;
  logic         l1, l2, l3;
  logic         carry;

  always_comb begin
    // phase 1: clears
    a1 = ctl.clr_ac ? '0 : ac;
    l1 = ctl.clr_l ? 1'b0 : l;
    // phase 2: complements
    a2 = ctl.cmp_ac ? ~a1 : a1;
    l2 = ctl.cmp_l ? ~l1 : l1;
    // phase 3a: increment with carry into link
    {carry, a3} = {1'b0, a2} + {{W{1'b0}}, ctl.inc_ac};
    l3 = l2 ^ carry;
    // phase 3b: switch OR with link inversion
    ac_n = ctl.or_sw ? (a3 | sw) : a3;
    l_n  = l3 ^ ctl.or_sw;
  end
endmodule

// File: rtl/opr_runflag.sv
module opr_runflag (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic halt_take,
  output logic running
);
  logic run_d;

  always_comb begin
    run_d = start | (running & ~halt_take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= run_d;
  end
endmodule

// File: rtl/opr_unit.sv
module opr_unit
  import opr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         instr_valid,
  input  logic [W-1:0] instr,
  input  logic [W-1:0] switches,
  output logic [W-1:0] acc,
  output logic         link,
  output logic         running
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  opr_ctl_t               ctl;
  logic [W-1:0]           ac_n;
  logic                   l_n;
  logic                   accept;
  logic                   run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  opr_decode #(.W(W)) u_dec (.instr(instr), .ctl(ctl));

  opr_alu #(.W(W)) u_alu (
    .ctl(ctl), .ac(acc), .l(link), .sw(switches), .ac_n(ac_n), .l_n(l_n)
  );

  assign accept = instr_valid & run_q & ctl.legal;

  opr_runflag u_run (
    .clk(clk), .rst_n(rst_int_n), .start(start),
    .halt_take(accept & ctl.halt), .running(run_q)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc  <= '0;
      link <= 1'b0;
    end else if (accept) begin
      acc  <= ac_n;
      link <= l_n;
    end
  end

  assign running = run_q;
endmodule

// File: rtl/opr_unit_chk.sv
module opr_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         instr_valid,
  input logic [W-1:0] instr,
  input logic [W-1:0] acc,
  input logic         link,
  input logic         running
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R2
  rise_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(running)) |-> $past(start));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !running) |=> ($stable(acc) && $stable(link)));

  // R8
  halt_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && instr_valid && !instr[W-1] && !(|instr[W-2:6]) && !start)
    |=> !running);

  // R9
  nongroup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && instr_valid && (|instr[W-2:6]))
    |=> ($stable(acc) && $stable(link)));

  // R4
  all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && instr_valid && instr == {1'b1, {(W-3){1'b0}}, 2'b11})
    |=> (acc == {W{1'b1}}));
endmodule

bind opr_unit opr_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .instr_valid(instr_valid),
  .instr(instr), .acc(acc), .link(link), .running(running)
);

// File: tb/opr_unit_test.sv
module opr_unit_test;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic        instr_valid;
  logic [15:0] instr;
  logic [15:0] switches;
  logic [15:0] acc;
  logic        link;
  logic        running;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] ac;
    logic        l;
    logic        run;
    string       tag;
  } exp_t;

  exp_t q[$];

  logic [15:0] m_ac;
  logic        m_l;
  logic        m_run;

  opr_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_valid(instr_valid),
    .instr(instr), .switches(switches), .acc(acc), .link(link),
    .running(running)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(string tag, logic [15:0] a, logic [15:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, a, e);
    end
  endtask

  // reference model from the requirement text
  task automatic model(logic st, logic v, logic [15:0] w, logic [15:0] sw);
    int t;
    if (v && m_run && (w & 16'h7FC0) == 0) begin
      if (w[0]) m_ac = 0;
      if (w[3]) m_l = 0;
      if (w[1]) m_ac = m_ac ^ 16'hFFFF;
      if (w[4]) m_l = !m_l;
      if (w[2]) begin
        t = int'(m_ac) + 1;
        if (t > 65535) m_l = !m_l;
        m_ac = t[15:0];
      end
      if (w[5]) begin
        m_ac = m_ac | sw;
        m_l = !m_l;
      end
      if (!w[15]) m_run = 0;
    end
    if (st) m_run = 1;
  endtask

  task automatic drive(string tag, logic st, logic v, logic [15:0] w,
                       logic [15:0] sw);
    exp_t e;
    @(negedge clk);
    start = st; instr_valid = v; instr = w; switches = sw;
    model(st, v, w, sw);
    e.ac = m_ac; e.l = m_l; e.run = m_run; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    start = 0; instr_valid = 0;
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " acc"}, acc, e.ac);
      check({e.tag, " link"}, {15'd0, link}, {15'd0, e.l});
      check({e.tag, " run"}, {15'd0, running}, {15'd0, e.run});
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; instr_valid = 0; instr = 0; switches = 0;
    m_ac = 0; m_l = 0; m_run = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 acc", acc, 16'h0);
    check("R1 link", {15'd0, link}, 16'h0);
    check("R1 run", {15'd0, running}, 16'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R2 ignored while halted, and in the start cycle
    drive("R2 idle", 0, 1, 16'h8003, 16'h0);
    drive("R2 start", 1, 1, 16'h8003, 16'h0);
    // R4 / R10 clear then complement
    drive("R4 ones", 0, 1, 16'h8003, 16'h0);
    // R3 clear AC and link
    drive("R3 setl", 0, 1, 16'h8010, 16'h0);
    drive("R3 clear", 0, 1, 16'h8009, 16'h0);
    // R6 load switches
    drive("R6 load", 0, 1, 16'h8021, 16'h1234);
    drive("R6 or", 0, 1, 16'h8020, 16'h8001);
    // R5 negate
    drive("R5 neg", 0, 1, 16'h8006, 16'h0);
    // R5 carry out toggles link
    drive("R5 ones", 0, 1, 16'h8003, 16'h0);
    drive("R5 carry", 0, 1, 16'h8004, 16'h0);
    // R7 increment before OR
    drive("R7 ones", 0, 1, 16'h8003, 16'h0);
    drive("R7 order", 0, 1, 16'h8024, 16'h0001);
    // R9 non-group word
    drive("R9 ignore", 0, 1, 16'h8043, 16'hFFFF);
    drive("R9 ignore2", 0, 1, 16'h4001, 16'hFFFF);
    // R8 halt applies actions and stops
    drive("R8 halt", 0, 1, 16'h0002, 16'h0);
    drive("R8 after", 0, 1, 16'h8001, 16'h0);
    drive("R8 restart", 1, 0, 16'h0, 16'h0);
    drive("R8 halt+start", 1, 1, 16'h0000, 16'h0);
    drive("R8 still", 0, 1, 16'h8004, 16'h0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule